// File: doc/BRIEF.md
# Receive Frame Timestamp Filter

This block sits in the receive path of a time-triggered bus controller, after frame decoding. The first payload bytes of each received frame carry an application header of programmable length and a big-endian timestamp of up to four bytes, counted in macroticks. As bytes stream past, the filter checks the header against a programmed value and collects the timestamp. It keeps no copy of the payload, so the receive path itself gains no latency.

At the end-of-slot strobe the filter gives one verdict for the frame. A frame goes to the host store only if all of these hold: the decoder confirmed the frame, it is long enough, its header matches, and, when the age check is enabled, its age against the current macrotick time is within a programmed limit. Otherwise the frame is dropped, and a reason code tells why. A frame that has a matching header and arrives in one programmed critical slot raises an interrupt line in the same cycle as the verdict. The host does not have to parse the frame for this.

Top module: `rx_stamp_filter`

## Requirements
- R1: While reset is high, and after it until the first verdict, dec_valid, dec_forward, dec_drop and irq_crit are low and dec_reason is 0.
- R2: A verdict (dec_valid high for one cycle) appears in the cycle after rx_eos, and only if rx_sof was seen in that slot. An end-of-slot with no frame gives no verdict.
- R3: If rx_frame_ok did not pulse between rx_sof and rx_eos, or if the frame had fewer than cfg_hdr_len + cfg_ts_len bytes, the frame is dropped with reason 3. This reason has the highest priority.
- R4: Payload byte i, for i < cfg_hdr_len, must equal cfg_hdr_value[8i+7:8i]. Any mismatch drops the frame with reason 2. A header length of 0 always matches.
- R5: The timestamp is the cfg_ts_len bytes (0 to 4) that follow the header, most significant byte first.
- R6: The age is (now_time − timestamp) mod 2^(8·cfg_ts_len), with now_time sampled in the rx_eos cycle. When cfg_ts_en is 1 and age > cfg_max_age, the frame is dropped with reason 1. An age equal to the limit is accepted.
- R7: When cfg_ts_en is 0, the age never causes a drop.
- R8: irq_crit pulses together with the verdict when cfg_crit_en is 1, rx_slot_id equals cfg_crit_slot, the frame passes the R3 checks and the header matches. It pulses even if the frame is stale.
- R9: With a verdict, exactly one of dec_forward and dec_drop is high. dec_forward goes with reason 0. Without a verdict, both are low.
- R10: Payload bytes after the header and timestamp have no effect on the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_sof | input | 1 | Start of a decoded frame, one cycle before its first byte |
| rx_byte_vld | input | 1 | Payload byte strobe |
| rx_byte | input | 8 | Payload byte |
| rx_frame_ok | input | 1 | Frame-level valid pulse from the decoder |
| rx_eos | input | 1 | End-of-slot strobe |
| rx_slot_id | input | SLOT_W | Slot number of the current slot |
| now_time | input | TIME_W | Current macrotick time |
| cfg_hdr_len | input | HL_W | Header length in bytes |
| cfg_hdr_value | input | 8·HDR_BYTES | Expected header, byte i in bits 8i+7:8i |
| cfg_ts_len | input | TL_W | Timestamp length in bytes |
| cfg_ts_en | input | 1 | Enables the age check |
| cfg_max_age | input | 8·TS_BYTES | Largest accepted age in macroticks |
| cfg_crit_en | input | 1 | Enables the critical-slot interrupt |
| cfg_crit_slot | input | SLOT_W | Critical slot number |
| dec_valid | output | 1 | Verdict strobe |
| dec_forward | output | 1 | Pass the frame to the host store |
| dec_drop | output | 1 | Discard the frame |
| dec_reason | output | 2 | 0 accept, 1 stale, 2 header mismatch, 3 unconfirmed or short |
| irq_crit | output | 1 | Critical-frame interrupt pulse |

## Verification
The assertions assume well-formed slots. rx_sof comes in its own cycle before any payload byte. No byte, frame-ok pulse or sof shares a cycle with rx_eos. The configuration and slot number stay constant from rx_sof to rx_eos, and header and timestamp lengths do not exceed their parameters. The stimulus keeps to these rules by driving each frame through one task. That task changes configuration only between slots and always leaves idle cycles after the end-of-slot strobe.

// File: rtl/rx_stamp_filter_pkg.sv
package rx_stamp_filter_pkg;

    typedef enum logic [1:0] {
        RSN_ACCEPT = 2'd0,
        RSN_STALE  = 2'd1,
        RSN_HDR    = 2'd2,
        RSN_BAD    = 2'd3
    } reason_e;

    typedef struct packed {
        logic    vld;
        logic    fwd;
        logic    drop;
        reason_e rsn;
        logic    irq;
    } verdict_t;

    localparam verdict_t VERDICT_IDLE = '{vld: 1'b0, fwd: 1'b0, drop: 1'b0,
                                          rsn: RSN_ACCEPT, irq: 1'b0};

    // Priority: unconfirmed/short, then header, then age.
    function automatic reason_e pick_reason(input logic bad, input logic hdr_ok,
                                            input logic stale);
        if (bad)          return RSN_BAD;
        else if (!hdr_ok) return RSN_HDR;
        else if (stale)   return RSN_STALE;
        else              return RSN_ACCEPT;
    endfunction

endpackage

// File: rtl/rx_stamp_capture.sv
module rx_stamp_capture #(
    parameter int HDR_BYTES = 4,
    parameter int TS_BYTES  = 4,
    localparam int HL_W  = $clog2(HDR_BYTES + 1),
    localparam int TL_W  = $clog2(TS_BYTES + 1),
    localparam int CNT_W = $clog2(HDR_BYTES + TS_BYTES + 1) + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   rx_sof,
    input  logic                   rx_byte_vld,
    input  logic [7:0]             rx_byte,
    input  logic                   rx_frame_ok,
    input  logic                   rx_eos,
    input  logic [HL_W-1:0]        cfg_hdr_len,
    input  logic [TL_W-1:0]        cfg_ts_len,
    input  logic [8*HDR_BYTES-1:0] cfg_hdr_value,
    output logic [CNT_W-1:0]       cap_cnt,
    output logic                   hdr_match,
    output logic [8*TS_BYTES-1:0]  ts_raw,
    output logic                   frame_open,
    output logic                   ok_seen
);
    localparam logic [CNT_W-1:0] CNT_SAT = '1;

    logic [CNT_W-1:0]      hdr_end, ts_end;
    logic [7:0]            exp_byte;
    logic                  in_hdr, in_ts;
    logic [8*TS_BYTES-1:0] ts_shift;

    assign hdr_end = CNT_W'(cfg_hdr_len);
    assign ts_end  = hdr_end + CNT_W'(cfg_ts_len);
    assign in_hdr  = cap_cnt < hdr_end;
    assign in_ts   = !in_hdr && (cap_cnt < ts_end);

    always_comb begin
        exp_byte = '0;
        for (int i = 0; i < HDR_BYTES; i++)
            if (cap_cnt == CNT_W'(i)) exp_byte = cfg_hdr_value[8*i +: 8];
        ts_shift = ts_raw << 8;
        ts_shift[7:0] = rx_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_cnt    <= '0;
            hdr_match  <= 1'b1;
            ts_raw     <= '0;
            frame_open <= 1'b0;
            ok_seen    <= 1'b0;
        end else if (rx_sof) begin
            cap_cnt    <= '0;
            hdr_match  <= 1'b1;
            ts_raw     <= '0;
            frame_open <= 1'b1;
            ok_seen    <= 1'b0;
        end else if (rx_eos) begin
            frame_open <= 1'b0;
            ok_seen    <= 1'b0;
        end else begin
            if (rx_frame_ok && frame_open) ok_seen <= 1'b1;
            if (rx_byte_vld && frame_open) begin
                if (cap_cnt != CNT_SAT) cap_cnt <= cap_cnt + 1'b1;
                if (in_hdr && (rx_byte != exp_byte)) hdr_match <= 1'b0;
                if (in_ts) ts_raw <= ts_shift;
            end
        end
    end

    // R10: bytes past the header and timestamp leave the captured fields alone
    a_r10_tail_ignored: assert property (@(posedge clk) disable iff (rst)
        (rx_byte_vld && !rx_sof && !rx_eos && (cap_cnt >= ts_end))
        |=> ($stable(ts_raw) && $stable(hdr_match)));

    // R2: the slot context closes at end-of-slot
    a_r2_close_at_eos: assert property (@(posedge clk) disable iff (rst)
        (rx_eos && !rx_sof) |=> (!frame_open && !ok_seen));

endmodule

// File: rtl/rx_stamp_age.sv
module rx_stamp_age #(
    parameter int TS_BYTES = 4,
    parameter int TIME_W   = 32,
    localparam int TL_W = $clog2(TS_BYTES + 1),
    localparam int TW   = 8 * TS_BYTES
) (
    input  logic [TL_W-1:0]   cfg_ts_len,
    input  logic [TW-1:0]     ts_raw,
    input  logic [TIME_W-1:0] now_time,
    input  logic [TW-1:0]     cfg_max_age,
    output logic              too_old
);
    logic [TW-1:0] mask, diff, age;

    always_comb begin
        mask = '0;
        for (int i = 0; i < TS_BYTES; i++)
            if (i < int'(cfg_ts_len)) mask[8*i +: 8] = 8'hFF;
        diff    = now_time[TW-1:0] - ts_raw;
        age     = diff & mask;
        too_old = age > cfg_max_age;
    end

endmodule

// File: rtl/rx_stamp_filter.sv
module rx_stamp_filter
    import rx_stamp_filter_pkg::*;
#(
    parameter int HDR_BYTES = 4,
    parameter int TS_BYTES  = 4,
    parameter int SLOT_W    = 11,
    parameter int TIME_W    = 32,
    localparam int HL_W  = $clog2(HDR_BYTES + 1),
    localparam int TL_W  = $clog2(TS_BYTES + 1),
    localparam int CNT_W = $clog2(HDR_BYTES + TS_BYTES + 1) + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   rx_sof,
    input  logic                   rx_byte_vld,
    input  logic [7:0]             rx_byte,
    input  logic                   rx_frame_ok,
    input  logic                   rx_eos,
    input  logic [SLOT_W-1:0]      rx_slot_id,
    input  logic [TIME_W-1:0]      now_time,
    input  logic [HL_W-1:0]        cfg_hdr_len,
    input  logic [8*HDR_BYTES-1:0] cfg_hdr_value,
    input  logic [TL_W-1:0]        cfg_ts_len,
    input  logic                   cfg_ts_en,
    input  logic [8*TS_BYTES-1:0]  cfg_max_age,
    input  logic                   cfg_crit_en,
    input  logic [SLOT_W-1:0]      cfg_crit_slot,
    output logic                   dec_valid,
    output logic                   dec_forward,
    output logic                   dec_drop,
    output logic [1:0]             dec_reason,
    output logic                   irq_crit
);
    logic [CNT_W-1:0]      cap_cnt;
    logic                  hdr_match, frame_open, ok_seen, too_old;
    logic [8*TS_BYTES-1:0] ts_raw;
    logic                  short_frame, bad_frame, fire;
    reason_e               rsn_now;
    verdict_t              vq;

    rx_stamp_capture #(.HDR_BYTES(HDR_BYTES), .TS_BYTES(TS_BYTES)) u_capture (
        .clk(clk), .rst(rst), .rx_sof(rx_sof), .rx_byte_vld(rx_byte_vld),
        .rx_byte(rx_byte), .rx_frame_ok(rx_frame_ok), .rx_eos(rx_eos),
        .cfg_hdr_len(cfg_hdr_len), .cfg_ts_len(cfg_ts_len),
        .cfg_hdr_value(cfg_hdr_value), .cap_cnt(cap_cnt), .hdr_match(hdr_match),
        .ts_raw(ts_raw), .frame_open(frame_open), .ok_seen(ok_seen)
    );

    rx_stamp_age #(.TS_BYTES(TS_BYTES), .TIME_W(TIME_W)) u_age (
        .cfg_ts_len(cfg_ts_len), .ts_raw(ts_raw), .now_time(now_time),
        .cfg_max_age(cfg_max_age), .too_old(too_old)
    );

    assign short_frame = cap_cnt < (CNT_W'(cfg_hdr_len) + CNT_W'(cfg_ts_len));
    assign bad_frame   = !ok_seen || short_frame;
    assign rsn_now     = pick_reason(bad_frame, hdr_match, cfg_ts_en && too_old);
    assign fire        = rx_eos && frame_open;

    always_ff @(posedge clk) begin
        if (rst || !fire) begin
            vq <= VERDICT_IDLE;
        end else begin
            vq.vld  <= 1'b1;
            vq.fwd  <= (rsn_now == RSN_ACCEPT);
            vq.drop <= (rsn_now != RSN_ACCEPT);
            vq.rsn  <= rsn_now;
            vq.irq  <= cfg_crit_en && (rx_slot_id == cfg_crit_slot)
                       && !bad_frame && hdr_match;
        end
    end

    assign dec_valid   = vq.vld;
    assign dec_forward = vq.fwd;
    assign dec_drop    = vq.drop;
    assign dec_reason  = vq.rsn;
    assign irq_crit    = vq.irq;

    // R2: a verdict only follows an end-of-slot
    a_r2_after_eos: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> $past(rx_eos));

    // R9: exactly one disposition with a verdict, none without
    a_r9_one_disposition: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> $onehot({dec_forward, dec_drop}));
    a_r9_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> (!dec_forward && !dec_drop && !irq_crit));

    // R3: an unconfirmed frame is dropped with the top-priority reason
    a_r3_unconfirmed: assert property (@(posedge clk) disable iff (rst)
        (rx_eos && frame_open && !ok_seen) |=> (dec_drop && dec_reason == 2'd3));

    // R7: no stale verdict while the age check is off
    a_r7_no_stale_when_off: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !$past(cfg_ts_en)) |-> (dec_reason != 2'd1));

    // R8: the interrupt only comes with a confirmed, header-matched verdict
    a_r8_irq_with_verdict: assert property (@(posedge clk) disable iff (rst)
        irq_crit |-> (dec_valid && dec_reason[1] == 1'b0));

endmodule

// File: tb/tb_rx_stamp_filter.sv
module tb_rx_stamp_filter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_sof = 0, rx_byte_vld = 0, rx_frame_ok = 0, rx_eos = 0;
    logic [7:0]  rx_byte = 0;
    logic [10:0] rx_slot_id = 0;
    logic [31:0] now_time = 0;
    logic [2:0]  cfg_hdr_len = 3'd2, cfg_ts_len = 3'd4;
    logic [31:0] cfg_hdr_value = 32'h0000B2A1;
    logic        cfg_ts_en = 1'b1, cfg_crit_en = 1'b1;
    logic [31:0] cfg_max_age = 32'd100;
    logic [10:0] cfg_crit_slot = 11'd7;
    logic        dec_valid, dec_forward, dec_drop, irq_crit;
    logic [1:0]  dec_reason;

    rx_stamp_filter dut (
        .clk(clk), .rst(rst), .rx_sof(rx_sof), .rx_byte_vld(rx_byte_vld),
        .rx_byte(rx_byte), .rx_frame_ok(rx_frame_ok), .rx_eos(rx_eos),
        .rx_slot_id(rx_slot_id), .now_time(now_time), .cfg_hdr_len(cfg_hdr_len),
        .cfg_hdr_value(cfg_hdr_value), .cfg_ts_len(cfg_ts_len),
        .cfg_ts_en(cfg_ts_en), .cfg_max_age(cfg_max_age),
        .cfg_crit_en(cfg_crit_en), .cfg_crit_slot(cfg_crit_slot),
        .dec_valid(dec_valid), .dec_forward(dec_forward), .dec_drop(dec_drop),
        .dec_reason(dec_reason), .irq_crit(irq_crit)
    );

    always #4 clk = ~clk;

    int n_checks = 0, n_fail = 0, dec_seen = 0;
    logic [4:0] expq[$];   // {fwd, drop, reason[1:0], irq}
    string      tagq[$];
    logic [7:0] pay [16];
    bit         done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic load(input logic [71:0] v);
        for (int i = 0; i < 9; i++) pay[i] = v[71-8*i -: 8];
    endtask

    function automatic logic [4:0] model(input int slot, input int n, input bit ok,
                                         input logic [31:0] now);
        int hl = int'(cfg_hdr_len), tl = int'(cfg_ts_len);
        bit bad, hm = 1, stale;
        logic [63:0] ts = 0, mask, age;
        logic [1:0] r;
        bad = !ok || (n < hl + tl);
        for (int i = 0; i < hl; i++) if (pay[i] != cfg_hdr_value[8*i +: 8]) hm = 0;
        for (int j = 0; j < tl; j++) ts = (ts << 8) | 64'(pay[hl+j]);
        mask  = (64'd1 << (8*tl)) - 1;
        age   = (64'(now) - ts) & mask;
        stale = cfg_ts_en && (age > 64'(cfg_max_age));
        r = bad ? 2'd3 : !hm ? 2'd2 : stale ? 2'd1 : 2'd0;
        return {r == 2'd0, r != 2'd0, r,
                cfg_crit_en && (slot == int'(cfg_crit_slot)) && !bad && hm};
    endfunction

    task automatic send(input string tag, input int slot, input int n, input bit ok,
                        input logic [31:0] now, input bit has_frame = 1);
        rx_slot_id = 11'(slot);
        if (has_frame) begin
            rx_sof = 1; tick(); rx_sof = 0;
            for (int i = 0; i < n; i++) begin
                rx_byte_vld = 1; rx_byte = pay[i]; tick();
            end
            rx_byte_vld = 0;
            if (ok) begin rx_frame_ok = 1; tick(); rx_frame_ok = 0; end
            expq.push_back(model(slot, n, ok, now));
            tagq.push_back(tag);
        end
        now_time = now; rx_eos = 1; tick(); rx_eos = 0;
        repeat (3) tick();
    endtask

    // Monitor: pop and compare each verdict
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (dec_valid) begin
                dec_seen++;
                if (expq.size() == 0) begin
                    chk(0, "R2 unexpected verdict", 1, 0);
                end else begin
                    automatic logic [4:0] e = expq.pop_front();
                    automatic string t = tagq.pop_front();
                    chk({dec_forward, dec_drop, dec_reason, irq_crit} == e, t,
                        {dec_forward, dec_drop, dec_reason, irq_crit}, e);
                end
            end else if (dec_forward || dec_drop || irq_crit) begin
                chk(0, "R9 stray output", {dec_forward, dec_drop, irq_crit}, 0);
            end
        end
    end

    task automatic finish_up();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_up();
    end

    initial begin
        int seen0;
        repeat (3) tick();
        @(negedge clk);
        chk({dec_valid, dec_forward, dec_drop, dec_reason, irq_crit} == 0,
            "R1 reset state", {dec_valid, dec_forward, dec_drop, dec_reason, irq_crit}, 0);
        rst = 0;
        repeat (2) tick();
        @(negedge clk);
        chk({dec_valid, dec_forward, dec_drop, irq_crit} == 0, "R1 idle after reset",
            {dec_valid, dec_forward, dec_drop, irq_crit}, 0);
        tick();

        load(72'hA1B2_00001000_000000);
        send("R5 R9 fresh frame", 3, 6, 1, 32'h1020);
        send("R6 age equal limit", 3, 6, 1, 32'h1000 + 100);
        send("R6 age over limit", 3, 6, 1, 32'h1000 + 101);
        send("R10 trailing bytes", 4, 9, 1, 32'h1001);
        send("R3 unconfirmed", 3, 6, 0, 32'h1001);
        send("R3 short frame", 3, 5, 1, 32'h1001);
        send("R8 critical slot", 7, 6, 1, 32'h1010);
        send("R8 critical and stale", 7, 6, 1, 32'h2000);
        load(72'hA1B3_00001000_000000);
        send("R4 header mismatch", 3, 6, 1, 32'h1001);
        send("R8 critical header mismatch", 7, 6, 1, 32'h1001);

        load(72'hA1B2_00001000_FFEEDD);
        cfg_ts_en = 0;
        send("R7 age check off", 3, 9, 1, 32'h9000_0000);
        cfg_ts_en = 1;

        cfg_ts_len = 3'd2;
        load(72'hA1B2_FFF0_00000000_00);
        send("R6 wrap 16-bit", 3, 4, 1, 32'hABCD_0005);
        send("R6 wrap 16-bit stale", 3, 4, 1, 32'h0000_0100);

        cfg_hdr_len = 3'd0; cfg_ts_len = 3'd1;
        load(72'h50_77_000000000000_00);
        send("R4 empty header", 3, 2, 1, 32'h1234_5658);
        send("R3 zero length frame", 3, 0, 1, 32'h0);

        seen0 = dec_seen;
        send("R2 no frame", 3, 0, 1, 32'h0, 0);
        chk(dec_seen == seen0, "R2 no verdict without frame", dec_seen - seen0, 0);
        chk(expq.size() == 0, "R2 all verdicts arrived", expq.size(), 0);
        finish_up();
    end

endmodule